// File: doc/BRIEF.md
# Logic Instruction Register Executor

This block accepts 16-bit instruction words and executes the bitwise logic group in a single clock: AND, OR and XOR between two general registers, complement of one register into another, and AND, OR, XOR or a zero test of register 0 against an 8-bit constant carried in the word. It owns a file of sixteen 32-bit general registers and one test flag, which only the test instructions modify.

A host presents a word on `instr_i` with `instr_valid_i` high. The result lands in the destination register on the next rising clock edge. A side port reads any register combinationally and writes one on the clock edge, so the host can preload operands and inspect results. A word outside the supported patterns is reported on `illegal_o` during the cycle in which it is presented, and it modifies nothing.

Top module: `logic_exec`

## Requirements
- R1: While `rst_n` is low, all sixteen registers clear to zero and `t_flag_o` clears to 0. After reset, `illegal_o` is 0 while `instr_valid_i` is low.
- R2: A word of the form 0010 nnnn mmmm cccc, with `cccc` equal to 1001 (AND), 1011 (OR) or 1010 (XOR), writes `Rn op Rm` into Rn at the next clock edge. Here `nnnn` is bits 11:8 and `mmmm` is bits 7:4.
- R3: A word of the form 0110 nnnn mmmm 0111 writes the bitwise complement of Rm into Rn at the next clock edge.
- R4: A word of the form 11001 ooo followed by an 8-bit constant in bits 7:0 zero-extends the constant to 32 bits. It then writes `R0 op constant` into R0, with `ooo` equal to 001 for AND, 011 for OR and 010 for XOR.
- R5: The test forms are 0010 nnnn mmmm 1000 (operands Rn and Rm) and 11001 000 followed by a constant (operands R0 and the zero-extended constant). Each sets `t_flag_o` to 1 at the next edge when the AND of its operands is zero, and to 0 otherwise. Neither writes any register.
- R6: AND, OR, XOR and NOT, in both register and constant form, leave `t_flag_o` unchanged.
- R7: A word with `instr_valid_i` high that matches none of the patterns in R2 to R5 drives `illegal_o` high in that same cycle. It changes no register and does not change `t_flag_o`.
- R8: When `instr_valid_i` is low, the word on `instr_i` has no effect on any register or on `t_flag_o`, and `illegal_o` stays 0.
- R9: `dbg_rdata_o` shows the register selected by `dbg_addr_i` combinationally. When `dbg_we_i` is high, `dbg_wdata_i` is written into that register at the clock edge. A debug write and an instruction write to different registers in the same cycle both take effect.
- R10: A debug write and an instruction write must not target the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr_i | input | 16 | Instruction word |
| instr_valid_i | input | 1 | Instruction word is present this cycle |
| dbg_addr_i | input | 4 | Debug port register select |
| dbg_we_i | input | 1 | Debug write enable |
| dbg_wdata_i | input | 32 | Debug write data |
| dbg_rdata_o | output | 32 | Selected register contents, combinational |
| t_flag_o | output | 1 | Test flag |
| illegal_o | output | 1 | Presented word is not a supported instruction |

## Verification
Some properties are checked on every cycle. The test flag holds across any accepted word that is not a test form, and across any rejected word. `illegal_o` never rises without a valid strobe. A test form never raises the internal register write. Every constant-form write goes to register 0. No debug write collides with an instruction write. The actual result values cannot be seen by the assertions: the per-operation data results, the zero extension of the constant, the zero and nonzero outcomes of the test, and the coexistence of a debug write with an instruction write. Those only show up when the bench scenarios compare all sixteen registers and the flag against the reference model after each step.

// File: rtl/logic_exec_pkg.sv
package logic_exec_pkg;

  localparam int unsigned INSTR_W = 16;
  localparam int unsigned RSEL_W  = 4;   // register field width in the encoding
  localparam int unsigned CONST_W = 8;   // constant field width in the encoding

  typedef enum logic [2:0] {
    LOP_AND = 3'd0,
    LOP_OR  = 3'd1,
    LOP_XOR = 3'd2,
    LOP_NOT = 3'd3,
    LOP_TST = 3'd4
  } lop_e;

  typedef struct packed {
    logic               legal;
    lop_e               op;
    logic               use_const;
    logic               wr_en;
    logic               t_en;
    logic [RSEL_W-1:0]  dst;
    logic [RSEL_W-1:0]  src;
    logic [CONST_W-1:0] konst;
  } lop_dec_t;

endpackage

// File: rtl/logic_exec_decode.sv
module logic_exec_decode
  import logic_exec_pkg::*;
(
  input  logic [INSTR_W-1:0] word_i,
  input  logic               valid_i,
  output lop_dec_t           dec_o
);

  lop_dec_t raw;

  always_comb begin
    raw           = '0;
    raw.op        = LOP_AND;
    raw.dst       = word_i[11:8];
    raw.src       = word_i[7:4];
    raw.konst     = word_i[7:0];
    casez (word_i)
      16'b0010_????_????_1001: begin raw.legal = 1'b1; raw.op = LOP_AND; end
      16'b0010_????_????_1011: begin raw.legal = 1'b1; raw.op = LOP_OR;  end
      16'b0010_????_????_1010: begin raw.legal = 1'b1; raw.op = LOP_XOR; end
      16'b0010_????_????_1000: begin raw.legal = 1'b1; raw.op = LOP_TST; end
      16'b0110_????_????_0111: begin raw.legal = 1'b1; raw.op = LOP_NOT; end
      16'b1100_1001_????_????: begin raw.legal = 1'b1; raw.op = LOP_AND; raw.use_const = 1'b1; end
      16'b1100_1011_????_????: begin raw.legal = 1'b1; raw.op = LOP_OR;  raw.use_const = 1'b1; end
      16'b1100_1010_????_????: begin raw.legal = 1'b1; raw.op = LOP_XOR; raw.use_const = 1'b1; end
      16'b1100_1000_????_????: begin raw.legal = 1'b1; raw.op = LOP_TST; raw.use_const = 1'b1; end
      default: raw.legal = 1'b0;
    endcase
    if (raw.use_const) raw.dst = '0;
  end

  always_comb begin
    dec_o       = raw;
    dec_o.t_en  = valid_i & raw.legal & (raw.op == LOP_TST);
    dec_o.wr_en = valid_i & raw.legal & (raw.op != LOP_TST);
  end

endmodule

// File: rtl/logic_exec_alu.sv
module logic_exec_alu
  import logic_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  lop_e              op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o
);

  always_comb begin
    unique case (op_i)
      LOP_AND, LOP_TST: res_o = a_i & b_i;
      LOP_OR:           res_o = a_i | b_i;
      LOP_XOR:          res_o = a_i ^ b_i;
      LOP_NOT:          res_o = ~b_i;
      default:          res_o = a_i & b_i;
    endcase
  end

  assign zero_o = (res_o == '0);

endmodule

// File: rtl/logic_exec_regfile.sv
module logic_exec_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 16,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_a_i,
  input  logic [AW-1:0]     waddr_a_i,
  input  logic [DATA_W-1:0] wdata_a_i,
  input  logic              we_b_i,
  input  logic [AW-1:0]     waddr_b_i,
  input  logic [DATA_W-1:0] wdata_b_i,
  input  logic [AW-1:0]     raddr0_i,
  input  logic [AW-1:0]     raddr1_i,
  input  logic [AW-1:0]     raddr2_i,
  output logic [DATA_W-1:0] rdata0_o,
  output logic [DATA_W-1:0] rdata1_o,
  output logic [DATA_W-1:0] rdata2_o
);

  logic [DATA_W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_entry
    logic              hit_a, hit_b, en;
    logic [DATA_W-1:0] d;

    always_comb begin
      hit_a = we_a_i && (waddr_a_i == AW'(g));
      hit_b = we_b_i && (waddr_b_i == AW'(g));
      en    = hit_a | hit_b;
      d     = hit_a ? wdata_a_i : wdata_b_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[g] <= '0;
      else if (en) regs_q[g] <= d;
    end
  end

  assign rdata0_o = regs_q[raddr0_i];
  assign rdata1_o = regs_q[raddr1_i];
  assign rdata2_o = regs_q[raddr2_i];

endmodule

// File: rtl/logic_exec.sv
module logic_exec
  import logic_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 16,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       instr_i,
  input  logic              instr_valid_i,
  input  logic [AW-1:0]     dbg_addr_i,
  input  logic              dbg_we_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  output logic [DATA_W-1:0] dbg_rdata_o,
  output logic              t_flag_o,
  output logic              illegal_o
);

  lop_dec_t          dec;
  logic [DATA_W-1:0] opa, opb_reg, opb, res;
  logic              res_zero;
  logic              inst_we;
  logic [AW-1:0]     inst_waddr;
  logic              t_q, t_d;

  logic_exec_decode u_dec (
    .word_i  (instr_i),
    .valid_i (instr_valid_i),
    .dec_o   (dec)
  );

  assign inst_we    = dec.wr_en;
  assign inst_waddr = AW'(dec.dst);

  logic_exec_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_a_i    (inst_we),
    .waddr_a_i (inst_waddr),
    .wdata_a_i (res),
    .we_b_i    (dbg_we_i),
    .waddr_b_i (dbg_addr_i),
    .wdata_b_i (dbg_wdata_i),
    .raddr0_i  (inst_waddr),
    .raddr1_i  (AW'(dec.src)),
    .raddr2_i  (dbg_addr_i),
    .rdata0_o  (opa),
    .rdata1_o  (opb_reg),
    .rdata2_o  (dbg_rdata_o)
  );

  assign opb = dec.use_const ? {{(DATA_W-CONST_W){1'b0}}, dec.konst} : opb_reg;

  logic_exec_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (dec.op),
    .a_i    (opa),
    .b_i    (opb),
    .res_o  (res),
    .zero_o (res_zero)
  );

  always_comb begin
    t_d = t_q;
    if (dec.t_en) t_d = res_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_q <= 1'b0;
    else        t_q <= t_d;
  end

  assign t_flag_o  = t_q;
  assign illegal_o = instr_valid_i & ~dec.legal;

endmodule

// File: rtl/logic_exec_chk.sv
module logic_exec_chk #(
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   instr_i,
  input logic          instr_valid_i,
  input logic          dbg_we_i,
  input logic [AW-1:0] dbg_addr_i,
  input logic          t_flag_o,
  input logic          illegal_o,
  input logic          inst_we,
  input logic [AW-1:0] inst_waddr
);

  logic is_test, is_const;
  assign is_test  = (instr_i[15:12] == 4'b0010 && instr_i[3:0] == 4'b1000) ||
                    (instr_i[15:8] == 8'hC8);
  assign is_const = (instr_i[15:11] == 5'b11001);

  // R6 / R8: only an accepted test word may move the flag
  a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_valid_i && is_test) |=> $stable(t_flag_o));

  // R7: a rejected word leaves the flag alone
  a_r7_illegal_keeps_t: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> $stable(t_flag_o));

  // R8: no illegal report without a strobe
  a_r8_illegal_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> instr_valid_i);

  // R5: test words never write a register
  a_r5_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && is_test) |-> !inst_we);

  // R4: constant forms write only register 0
  a_r4_const_to_r0: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_we && is_const) |-> (inst_waddr == '0));

  // R10: no collision between debug and instruction writes
  a_r10_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_we && dbg_we_i) |-> (inst_waddr != dbg_addr_i));

endmodule

bind logic_exec logic_exec_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_i       (instr_i),
  .instr_valid_i (instr_valid_i),
  .dbg_we_i      (dbg_we_i),
  .dbg_addr_i    (dbg_addr_i),
  .t_flag_o      (t_flag_o),
  .illegal_o     (illegal_o),
  .inst_we       (inst_we),
  .inst_waddr    (inst_waddr)
);

// File: tb/logic_exec_tb.sv
module logic_exec_tb_top;

  localparam int CLK_PERIOD = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr_i = '0;
  logic        instr_valid_i = 1'b0;
  logic [3:0]  dbg_addr_i = '0;
  logic        dbg_we_i = 1'b0;
  logic [31:0] dbg_wdata_i = '0;
  logic [31:0] dbg_rdata_o;
  logic        t_flag_o;
  logic        illegal_o;

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [31:0] mregs [16];
  logic        mt;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_exec dut_i (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .instr_valid_i(instr_valid_i),
    .dbg_addr_i(dbg_addr_i), .dbg_we_i(dbg_we_i), .dbg_wdata_i(dbg_wdata_i),
    .dbg_rdata_o(dbg_rdata_o), .t_flag_o(t_flag_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Compare the whole visible state against the model (runs in the low clock phase)
  task automatic compare_all(input string req);
    for (int i = 0; i < 16; i++) begin
      dbg_addr_i = 4'(i);
      #1;
      chk(req, $sformatf("R%0d", i), dbg_rdata_o, mregs[i]);
    end
    chk(req, "T", {31'b0, t_flag_o}, {31'b0, mt});
  endtask

  // Behavioural model of one accepted word; returns whether it is supported
  function automatic logic model_exec(input logic [15:0] w);
    int n = w[11:8];
    int m = w[7:4];
    logic [31:0] k = {24'b0, w[7:0]};
    if (w[15:12] == 4'h2 && w[3:0] == 4'h9) begin mregs[n] = mregs[n] & mregs[m]; return 1; end
    if (w[15:12] == 4'h2 && w[3:0] == 4'hB) begin mregs[n] = mregs[n] | mregs[m]; return 1; end
    if (w[15:12] == 4'h2 && w[3:0] == 4'hA) begin mregs[n] = mregs[n] ^ mregs[m]; return 1; end
    if (w[15:12] == 4'h2 && w[3:0] == 4'h8) begin mt = ((mregs[n] & mregs[m]) == 0); return 1; end
    if (w[15:12] == 4'h6 && w[3:0] == 4'h7) begin mregs[n] = ~mregs[m]; return 1; end
    if (w[15:8] == 8'hC9) begin mregs[0] = mregs[0] & k; return 1; end
    if (w[15:8] == 8'hCB) begin mregs[0] = mregs[0] | k; return 1; end
    if (w[15:8] == 8'hCA) begin mregs[0] = mregs[0] ^ k; return 1; end
    if (w[15:8] == 8'hC8) begin mt = ((mregs[0] & k) == 0); return 1; end
    return 0;
  endfunction

  task automatic issue(input logic [15:0] w, input logic v, input string req);
    logic ok;
    @(negedge clk);
    instr_i = w;
    instr_valid_i = v;
    #1;
    ok = v ? model_exec(w) : 1'b1;
    chk(req, "illegal_o", {31'b0, illegal_o}, {31'b0, (v && !ok)});
    @(negedge clk);
    instr_valid_i = 1'b0;
    compare_all(req);
  endtask

  task automatic dbg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    dbg_addr_i = a; dbg_wdata_i = d; dbg_we_i = 1'b1;
    @(negedge clk);
    dbg_we_i = 1'b0;
    mregs[a] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mregs[i] = '0;
    mt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");
    chk("R1", "illegal_o idle", {31'b0, illegal_o}, 32'd0);

    // R9: preload through debug port
    for (int i = 0; i < 16; i++) dbg_write(4'(i), 32'h1111_1111 * i ^ 32'hA5C3_0F96);
    compare_all("R9");

    issue(16'h2129, 1'b1, "R2");   // AND R1,R2
    issue(16'h234B, 1'b1, "R2");   // OR  R3,R4
    issue(16'h256A, 1'b1, "R2");   // XOR R5,R6
    issue(16'h2779, 1'b1, "R2");   // AND R7,R7 (same register)
    issue(16'h6897, 1'b1, "R3");   // NOT R8,R9
    issue(16'h6AA7, 1'b1, "R3");   // NOT R10,R10
    issue(16'hC9FF, 1'b1, "R4");   // AND #FF: upper bits cleared (zero extension)
    issue(16'hCB80, 1'b1, "R4");   // OR  #80
    issue(16'hCA5A, 1'b1, "R4");   // XOR #5A

    // R5: test forms, zero and nonzero outcomes; R6: flag kept by plain ops
    issue(16'h2BBA, 1'b1, "R5");   // XOR R11,R11 -> 0
    issue(16'h2BC8, 1'b1, "R5");   // TST R11,R12 -> T=1
    issue(16'h2129, 1'b1, "R6");   // AND keeps T
    issue(16'h6DD7, 1'b1, "R6");   // NOT keeps T
    issue(16'h2CC8, 1'b1, "R5");   // TST R12,R12 nonzero -> T=0
    issue(16'hCB01, 1'b1, "R6");   // OR #01 keeps T=0
    issue(16'hC801, 1'b1, "R5");   // TST #01 on odd R0 -> T=0
    issue(16'hC900, 1'b1, "R4");   // AND #00 clears R0
    issue(16'hC8FF, 1'b1, "R5");   // TST #FF on zero -> T=1
    issue(16'hCAFF, 1'b1, "R6");   // XOR keeps T=1

    // R7: unsupported words
    issue(16'hCD12, 1'b1, "R7");
    issue(16'h212C, 1'b1, "R7");
    issue(16'h6127, 1'b1, "R3");
    issue(16'h6126, 1'b1, "R7");
    issue(16'hFFFF, 1'b1, "R7");
    issue(16'hC0F0, 1'b1, "R7");

    // R8: strobe low
    issue(16'h2129, 1'b0, "R8");
    issue(16'hC800, 1'b0, "R8");
    issue(16'hFFFF, 1'b0, "R8");

    // R9: debug write and instruction write to different registers in one cycle
    @(negedge clk);
    instr_i = 16'h2349; instr_valid_i = 1'b1;
    dbg_addr_i = 4'd5; dbg_wdata_i = 32'hDEAD_BEEF; dbg_we_i = 1'b1;
    @(negedge clk);
    instr_valid_i = 1'b0; dbg_we_i = 1'b0;
    void'(model_exec(16'h2349));
    mregs[5] = 32'hDEAD_BEEF;
    compare_all("R9");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule